// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Array Model

A cycle-based model of a 256 x 256 single-bit dynamic memory that a memory controller under test can drive. The controller works a multiplexed 8-bit address bus with three active-low strobes, all sampled on the rising edge of the system clock. The model finds strobe edges by comparing each strobe with its value from the previous cycle. When the row strobe falls, the row address is taken from the bus and the whole row is copied into a row buffer. While the row strobe stays low, each falling edge of the column strobe takes a column address from the bus. It then either drives that buffer bit out or overwrites it with the write data. When the row strobe rises, the buffer is written back into the array.

A row strobe pulse with no column access therefore refreshes the row. Several column pulses inside one row activation give page-mode access. Every row has an age counter that counts clock cycles since the row was last written back. If a row is opened after its age has passed a parameterised limit, a sticky violation flag is set. A column strobe that arrives without an open row is ignored and sets a sticky protocol-error flag. With these two flags a bench can judge the controller.

Top module: `dram_page_model`

## Requirements
- R1: After reset, rdata_vld, rdata, proto_err and refresh_late are all 0.
- R2: A column strobe fall sampled with the row strobe low, an open row and wr_en_n high makes rdata_vld 1 one cycle later, with rdata equal to the addressed bit of the open row. rdata_vld returns to 0 one cycle after the column strobe is sampled high.
- R3: A column strobe fall with wr_en_n low puts wdata into the addressed bit of the row buffer. A later read in the same activation returns the new value. The value reaches the array only when the row strobe rises, so a later activation of the row also returns it.
- R4: Any number of column accesses, mixing reads and writes to different columns, may take place inside one row activation, and each one acts on the same open row.
- R5: A row strobe pulse with no column strobe leaves every bit of that row unchanged.
- R6: rdata_vld is 1 only when the previous sampled values had the row strobe low, the column strobe low and wr_en_n high. It stays 0 during write accesses. rdata is 0 whenever rdata_vld is 0.
- R7: A column strobe fall while no row is open (row strobe sampled high) sets proto_err from the next cycle on, and the flag is sticky until reset. Such a pulse changes no stored bit, even with wr_en_n low.
- R8: On a row strobe fall, refresh_late becomes 1 if the selected row's age exceeds REFRESH_LIMIT, and the flag is sticky until reset. A row's age is cleared on its write-back and rises by one every cycle, saturating. Opening a row written back fewer than REFRESH_LIMIT cycles earlier leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write select for column accesses |
| mux_addr | input | ADDR_W (8) | Row address at row strobe fall, column address at column strobe fall |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Read data bit, 0 when not valid |
| rdata_vld | output | 1 | Read data valid |
| proto_err | output | 1 | Sticky flag for a column strobe without an open row |
| refresh_late | output | 1 | Sticky flag for opening a row past its refresh limit |

## Verification
The checker assumes that the strobes sit high (deasserted) while reset is applied. Its edge-based properties rely on that, because they compare against the values seen in the reset cycles. The bench holds every strobe high during reset. It changes inputs only on falling clock edges, so each strobe level is held for at least one full sampled cycle. Its random sessions open a row before any column pulse and read only cells whose value is already known. The protocol-error and late-refresh cases are applied on purpose, and only near the end, because both flags are sticky.

// File: rtl/dram_page_model.sv
module dram_page_model #(
  parameter int ADDR_W        = 8,
  parameter int REFRESH_LIMIT = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] mux_addr,
  input  logic              wdata,
  output logic              rdata,
  output logic              rdata_vld,
  output logic              proto_err,
  output logic              refresh_late
);
  localparam int NROWS = 1 << ADDR_W;
  localparam int NCOLS = 1 << ADDR_W;
  localparam int AGE_W = $clog2(REFRESH_LIMIT + 2);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(REFRESH_LIMIT + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(REFRESH_LIMIT);

  logic [NCOLS-1:0]  cells [NROWS];
  logic [AGE_W-1:0]  age   [NROWS];
  logic [NCOLS-1:0]  row_buf;
  logic [ADDR_W-1:0] row_sel, col_sel;
  logic row_open, col_open, row_q, col_q, vld_q, err_q, late_q;

  wire row_fall  = !row_stb_n && row_q;
  wire row_rise  = row_stb_n && !row_q;
  wire col_fall  = !col_stb_n && col_q;
  wire col_ok    = col_fall && !row_stb_n && row_open;
  wire col_bad   = col_fall && !col_ok;
  wire wb_now    = row_rise && row_open;
  wire col_open_d = !col_stb_n && !row_stb_n && row_open && (col_ok || col_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= 1'b1;
      col_q    <= 1'b1;
      row_open <= 1'b0;
      col_open <= 1'b0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      late_q   <= 1'b0;
      row_sel  <= '0;
      col_sel  <= '0;
    end else begin
      row_q    <= row_stb_n;
      col_q    <= col_stb_n;
      col_open <= col_open_d;
      vld_q    <= col_open_d && wr_en_n;
      if (row_fall) begin
        row_sel  <= mux_addr;
        row_open <= 1'b1;
        if (age[mux_addr] > AGE_LIM) late_q <= 1'b1;
      end else if (row_rise) begin
        row_open <= 1'b0;
      end
      if (col_ok)  col_sel <= mux_addr;
      if (col_bad) err_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (row_fall && rst_n)               row_buf <= cells[mux_addr];
    else if (col_ok && !wr_en_n && rst_n) row_buf[mux_addr] <= wdata;
    if (wb_now && rst_n)                 cells[row_sel] <= row_buf;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NROWS; r++) begin
      if (!rst_n)                                  age[r] <= '0;
      else if (wb_now && row_sel == ADDR_W'(r))     age[r] <= '0;
      else if (age[r] != AGE_SAT)                  age[r] <= age[r] + 1'b1;
    end
  end

  assign rdata        = vld_q ? row_buf[col_sel] : 1'b0;
  assign rdata_vld    = vld_q;
  assign proto_err    = err_q;
  assign refresh_late = late_q;
endmodule

// File: rtl/dram_page_model_chk.sv
module dram_page_model_chk (
  input logic clk,
  input logic rst_n,
  input logic row_stb_n,
  input logic col_stb_n,
  input logic wr_en_n,
  input logic rdata,
  input logic rdata_vld,
  input logic proto_err,
  input logic refresh_late
);
  assert_vld_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |-> ($past(!row_stb_n) && $past(!col_stb_n) && $past(wr_en_n)));

  assert_vld_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb_n) |=> !rdata_vld);

  assert_orphan_col_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(col_stb_n) && row_stb_n && $past(row_stb_n)) |=> proto_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(proto_err));

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(refresh_late));
endmodule

bind dram_page_model dram_page_model_chk u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .wr_en_n(wr_en_n), .rdata(rdata), .rdata_vld(rdata_vld),
  .proto_err(proto_err), .refresh_late(refresh_late)
);

// File: tb/sim_dram_page_model.sv
module sim_dram_page_model;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1, wdata = 1'b0;
  logic [7:0] mux_addr = '0;
  logic rdata, rdata_vld, proto_err, refresh_late;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [255:0] ref_mem [16];
  logic [255:0] known   [16];
  logic [255:0] sess;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_model #(.ADDR_W(8), .REFRESH_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .mux_addr(mux_addr), .wdata(wdata), .rdata(rdata),
    .rdata_vld(rdata_vld), .proto_err(proto_err), .refresh_late(refresh_late));

  function automatic logic exp_bit(input logic [255:0] r, input int c);
    return r[c];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic open_row(input int r);
    mux_addr = 8'(r); row_stb_n = 1'b0; tick();
  endtask

  task automatic close_row();
    row_stb_n = 1'b1; tick();
  endtask

  task automatic rd(input int c, input logic exp, input string req);
    mux_addr = 8'(c); wr_en_n = 1'b1; col_stb_n = 1'b0; tick();
    check(rdata_vld === 1'b1, {req, " vld"}, int'(rdata_vld), 1);
    check(rdata === exp, {req, " data"}, int'(rdata), int'(exp));
    col_stb_n = 1'b1; tick();
    check(rdata_vld === 1'b0 && rdata === 1'b0, "R2/R6 vld low after col release", int'(rdata_vld), 0);
  endtask

  task automatic wr(input int c, input logic d);
    mux_addr = 8'(c); wdata = d; wr_en_n = 1'b0; col_stb_n = 1'b0; tick();
    check(rdata_vld === 1'b0, "R6 vld low on write", int'(rdata_vld), 0);
    col_stb_n = 1'b1; wr_en_n = 1'b1; tick();
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin ref_mem[i] = '0; known[i] = '0; end
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R1
    check(rdata_vld === 1'b0 && rdata === 1'b0, "R1 outputs after reset", int'(rdata_vld), 0);
    check(proto_err === 1'b0 && refresh_late === 1'b0, "R1 flags after reset", int'(proto_err), 0);

    // R3 directed: write visible in same page, then after write-back
    open_row(2); sess = ref_mem[2];
    wr(40, 1'b1); sess[40] = 1'b1; known[2][40] = 1'b1;
    rd(40, exp_bit(sess, 40), "R3 same-page read");
    wr(41, 1'b0); sess[41] = 1'b0; known[2][41] = 1'b1;
    close_row(); ref_mem[2] = sess;
    open_row(2);
    rd(40, 1'b1, "R3 after write-back");
    rd(41, 1'b0, "R3 after write-back");
    close_row();

    // R4 page mode: many columns mixed
    open_row(3); sess = ref_mem[3];
    for (int c = 0; c < 8; c++) begin
      wr(c * 31, 1'(c % 3 == 1)); sess[c * 31] = 1'(c % 3 == 1); known[3][c * 31] = 1'b1;
    end
    for (int c = 7; c >= 0; c--) rd(c * 31, exp_bit(sess, c * 31), "R4 page read");
    close_row(); ref_mem[3] = sess;

    // R5 refresh-only keeps contents
    open_row(3); close_row();
    open_row(3); close_row();
    open_row(3);
    for (int c = 0; c < 8; c++) rd(c * 31, exp_bit(ref_mem[3], c * 31), "R5 after refresh");
    close_row();

    // Random sessions (R2, R3, R4)
    for (int s = 0; s < 120; s++) begin
      int r, n;
      r = int'($urandom % 16);
      n = 1 + int'($urandom % 4);
      open_row(r); sess = ref_mem[r];
      for (int k = 0; k < n; k++) begin
        int c;
        c = int'($urandom % 256);
        if (!known[r][c] || ($urandom % 2 == 0)) begin
          logic d;
          d = 1'($urandom);
          wr(c, d); sess[c] = d; known[r][c] = 1'b1;
        end else begin
          rd(c, exp_bit(sess, c), "R2 random read");
        end
      end
      close_row(); ref_mem[r] = sess;
    end

    check(proto_err === 1'b0, "R7 no error on legal traffic", int'(proto_err), 0);

    // R7 orphan column strobe with write select low
    mux_addr = 8'd40; wdata = 1'b0; wr_en_n = 1'b0; col_stb_n = 1'b0; tick();
    check(rdata_vld === 1'b0, "R7 orphan no valid", int'(rdata_vld), 0);
    check(proto_err === 1'b1, "R7 orphan sets error", int'(proto_err), 1);
    col_stb_n = 1'b1; wr_en_n = 1'b1; tick();
    repeat (2) tick();
    check(proto_err === 1'b1, "R7 error sticky", int'(proto_err), 1);
    open_row(2);
    rd(40, exp_bit(ref_mem[2], 40), "R7 cell unchanged by orphan");
    close_row();

    // R8 refresh deadline
    check(refresh_late === 1'b0, "R8 no late flag yet", int'(refresh_late), 0);
    open_row(7); close_row();
    repeat (LIMIT - 200) tick();
    open_row(7);
    check(refresh_late === 1'b0, "R8 refreshed row in time", int'(refresh_late), 0);
    close_row();
    open_row(200);
    check(refresh_late === 1'b1, "R8 stale row flagged", int'(refresh_late), 1);
    close_row();
    repeat (3) tick();
    check(refresh_late === 1'b1, "R8 late flag sticky", int'(refresh_late), 1);

    done = 1;
    finish_up();
  end
endmodule